// File: doc/BRIEF.md
# I2C Pin Direct-Control Override

This block sits between an I2C controller and its two open-drain pads. In normal operation the controller's pull-low requests pass straight through to the SCL and SDA pads. When software needs to free a stuck bus, it flips a single mode bit. Both pins then come under register control: a direction mask, a latched output level, and separate write-one-to-set and write-one-to-clear ports for that level. Software can then pulse SCL by hand and watch SDA until the bus frees up.

The pads are open-drain. A pin is only ever pulled low or released, never forced high. A synchronized copy of both pad levels can be read at any time, whichever mode is active. The recovery sequence itself is left to software.

Top module: `i2c_pin_override`

## Requirements
- R1: After a synchronous reset, the block is in controller mode, both direction bits are input, the output latch is released (high) for both pins, and both pads are released.
- R2: In controller mode (mode bit 0), `scl_pad_low` equals `ctl_scl_low` and `sda_pad_low` equals `ctl_sda_low`, in the same cycle.
- R3: Register index 0 holds the mode bit in bit 0. Writing 1 gives both pins to register control and writing 0 returns both to the controller. The bit reads back at index 0.
- R4: Register index 1 holds the direction mask: bit 0 makes SCL an output and bit 1 makes SDA an output. It reads back at index 1. In register mode, a pin set to input is released, and the controller's requests have no effect on either pad.
- R5: A write to index 3 with a one in bit 0 (SCL) or bit 1 (SDA) sets that pin's latch high, which releases the pin from the cycle after the write edge.
- R6: A write to index 4 with a one in bit 0 (SCL) or bit 1 (SDA) clears that pin's latch. An output pin is then pulled low from the cycle after the write edge.
- R7: A zero bit in a write to index 3 or 4 leaves that pin's latch unchanged. Index 3 and index 4 both read back as zero.
- R8: Index 2 returns the pad levels (bit 0 SCL, bit 1 SDA) through a two-stage synchronizer. A pad change sampled at one edge is readable after the second edge, in either mode.
- R9: The output latch keeps its value across switches to controller mode and back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for write and read |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| ctl_scl_low | input | 1 | Controller request to pull SCL low |
| ctl_sda_low | input | 1 | Controller request to pull SDA low |
| scl_pad_in | input | 1 | Level seen on the SCL pad |
| sda_pad_in | input | 1 | Level seen on the SDA pad |
| scl_pad_low | output | 1 | Pull-low enable for the SCL pad |
| sda_pad_low | output | 1 | Pull-low enable for the SDA pad |

## Verification
Controller pass-through and register readback are combinational. The bench checks them one time unit after setting the inputs. A register write takes effect at the rising edge that samples it, so pad results are checked at the falling edge that follows that edge. A pad level takes two rising edges to reach index 2. The bench changes the pad at a falling edge and reads one falling edge later, expecting the old value, then again one falling edge after that, expecting the new value.

// File: rtl/i2cpm_pkg.sv
package i2cpm_pkg;

    localparam int PIN_N      = 2;
    localparam int REG_AW     = 3;
    localparam int PIN_SCL    = 0;
    localparam int PIN_SDA    = 1;

    typedef enum logic [REG_AW-1:0] {
        RG_MODE  = 3'd0,
        RG_DIR   = 3'd1,
        RG_LEVEL = 3'd2,
        RG_SET   = 3'd3,
        RG_CLR   = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic             gpio_mode;
        logic [PIN_N-1:0] dir_out;
        logic [PIN_N-1:0] latch;
    } pin_cfg_t;

    function automatic pin_cfg_t cfg_reset();
        pin_cfg_t c;
        c.gpio_mode = 1'b0;
        c.dir_out   = '0;
        c.latch     = '1;
        return c;
    endfunction

    function automatic logic pad_pull(logic gpio_mode, logic dir_out,
                                      logic latch, logic ctl_low);
        return gpio_mode ? (dir_out & ~latch) : ctl_low;
    endfunction

endpackage

// File: rtl/i2cpm_regs.sv
module i2cpm_regs
    import i2cpm_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output pin_cfg_t          cfg
);
    logic [PIN_N-1:0] mask;
    assign mask = wdata[PIN_N-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= cfg_reset();
        end else if (wr_en) begin
            case (addr)
                RG_MODE: cfg.gpio_mode <= wdata[0];
                RG_DIR:  cfg.dir_out   <= mask;
                RG_SET:  cfg.latch     <= cfg.latch | mask;
                RG_CLR:  cfg.latch     <= cfg.latch & ~mask;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2cpm_sync.sv
module i2cpm_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '1;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/i2cpm_pad.sv
module i2cpm_pad
    import i2cpm_pkg::*;
(
    input  logic gpio_mode,
    input  logic dir_out,
    input  logic latch,
    input  logic ctl_low,
    output logic drive_low
);
    always_comb drive_low = pad_pull(gpio_mode, dir_out, latch, ctl_low);
endmodule

// File: rtl/i2c_pin_override.sv
module i2c_pin_override
    import i2cpm_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ctl_scl_low,
    input  logic              ctl_sda_low,
    input  logic              scl_pad_in,
    input  logic              sda_pad_in,
    output logic              scl_pad_low,
    output logic              sda_pad_low
);
    pin_cfg_t         cfg_q;
    logic [PIN_N-1:0] ctl_bus;
    logic [PIN_N-1:0] pad_bus;
    logic [PIN_N-1:0] lvl_bus;
    logic [PIN_N-1:0] drv_bus;

    assign ctl_bus[PIN_SCL] = ctl_scl_low;
    assign ctl_bus[PIN_SDA] = ctl_sda_low;
    assign pad_bus[PIN_SCL] = scl_pad_in;
    assign pad_bus[PIN_SDA] = sda_pad_in;
    assign scl_pad_low      = drv_bus[PIN_SCL];
    assign sda_pad_low      = drv_bus[PIN_SDA];

    i2cpm_regs #(.DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .cfg   (cfg_q)
    );

    i2cpm_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_bus),
        .q   (lvl_bus)
    );

    for (genvar p = 0; p < PIN_N; p++) begin : g_pin
        i2cpm_pad u_pad (
            .gpio_mode (cfg_q.gpio_mode),
            .dir_out   (cfg_q.dir_out[p]),
            .latch     (cfg_q.latch[p]),
            .ctl_low   (ctl_bus[p]),
            .drive_low (drv_bus[p])
        );
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RG_MODE:  reg_rdata[0]         = cfg_q.gpio_mode;
            RG_DIR:   reg_rdata[PIN_N-1:0] = cfg_q.dir_out;
            RG_LEVEL: reg_rdata[PIN_N-1:0] = lvl_bus;
            default:  reg_rdata            = '0;
        endcase
    end
endmodule

// File: rtl/i2cpm_chk.sv
module i2cpm_chk
    import i2cpm_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [PIN_N-1:0]  ctl_low,
    input logic [PIN_N-1:0]  pad_in,
    input logic [PIN_N-1:0]  pad_low,
    input pin_cfg_t          cfg
);
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst) age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    a_r2_ctl_follow: assert property (@(posedge clk) disable iff (rst)
        !cfg.gpio_mode |-> pad_low == ctl_low);

    a_r5_set_release: assert property (@(posedge clk) disable iff (rst)
        (cfg.gpio_mode && reg_wr && reg_addr == RG_SET && reg_wdata[0])
        |=> !pad_low[0]);

    a_r6_clr_pull: assert property (@(posedge clk) disable iff (rst)
        (cfg.gpio_mode && cfg.dir_out[0] && reg_wr && reg_addr == RG_CLR && reg_wdata[0])
        |=> pad_low[0]);

    a_r7_zero_write: assert property (@(posedge clk) disable iff (rst)
        (cfg.gpio_mode && reg_wr && (reg_addr == RG_SET || reg_addr == RG_CLR)
         && reg_wdata[PIN_N-1:0] == '0)
        |=> $stable(pad_low));

    a_r8_sync_delay: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2 && reg_addr == RG_LEVEL) |-> reg_rdata[PIN_N-1:0] == $past(pad_in, 2));
endmodule

bind i2c_pin_override i2cpm_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ctl_low   (ctl_bus),
    .pad_in    (pad_bus),
    .pad_low   (drv_bus),
    .cfg       (cfg_q)
);

// File: tb/i2c_pin_override_test.sv
`timescale 1ns/1ps
module i2c_pin_override_test;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = 3'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          ctl_scl_low = 1'b0, ctl_sda_low = 1'b0;
    logic          scl_pad_in = 1'b1, sda_pad_in = 1'b1;
    logic          scl_pad_low, sda_pad_low;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    i2c_pin_override #(.DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ctl_scl_low(ctl_scl_low), .ctl_sda_low(ctl_sda_low),
        .scl_pad_in(scl_pad_in), .sda_pad_in(sda_pad_in),
        .scl_pad_low(scl_pad_low), .sda_pad_low(sda_pad_low)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [2:0] a, logic [15:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic pads_chk(string tag, logic scl_exp, logic sda_exp);
        #1;
        chk(tag, {14'd0, sda_pad_low, scl_pad_low}, {14'd0, sda_exp, scl_exp});
    endtask

    task automatic t_reset();
        pads_chk("R1 pads released", 1'b0, 1'b0);
        rd_chk("R1 mode reset", 3'd0, 16'h0);
        rd_chk("R1 dir reset", 3'd1, 16'h0);
    endtask

    task automatic t_controller();
        ctl_scl_low = 1'b1; ctl_sda_low = 1'b0;
        pads_chk("R2 ctl scl", 1'b1, 1'b0);
        ctl_scl_low = 1'b0; ctl_sda_low = 1'b1;
        pads_chk("R2 ctl sda", 1'b0, 1'b1);
    endtask

    task automatic t_mode();
        ctl_scl_low = 1'b1; ctl_sda_low = 1'b1;
        wr(3'd0, 16'h0001);
        rd_chk("R3 mode readback", 3'd0, 16'h1);
        pads_chk("R4 ctl ignored, inputs released", 1'b0, 1'b0);
    endtask

    task automatic t_dir_clr();
        wr(3'd1, 16'h0001);
        rd_chk("R4 dir readback", 3'd1, 16'h1);
        pads_chk("R4 out with latch high released", 1'b0, 1'b0);
        wr(3'd4, 16'h0001);
        pads_chk("R6 clr scl pulls low", 1'b1, 1'b0);
        wr(3'd1, 16'h0000);
        pads_chk("R4 input direction releases", 1'b0, 1'b0);
        wr(3'd1, 16'h0003);
        pads_chk("R6 latch low on output", 1'b1, 1'b0);
    endtask

    task automatic t_set();
        wr(3'd4, 16'h0002);
        pads_chk("R6 clr sda", 1'b1, 1'b1);
        wr(3'd3, 16'h0002);
        pads_chk("R5 set sda releases", 1'b1, 1'b0);
        wr(3'd3, 16'h0001);
        pads_chk("R5 set scl releases", 1'b0, 1'b0);
        wr(3'd4, 16'h0001);
        pads_chk("R6 clr scl again", 1'b1, 1'b0);
    endtask

    task automatic t_zero();
        wr(3'd3, 16'h0000);
        pads_chk("R7 set zero no effect", 1'b1, 1'b0);
        wr(3'd4, 16'h0000);
        pads_chk("R7 clr zero no effect", 1'b1, 1'b0);
        rd_chk("R7 set reads zero", 3'd3, 16'h0);
        rd_chk("R7 clr reads zero", 3'd4, 16'h0);
    endtask

    task automatic t_hold();
        ctl_scl_low = 1'b0; ctl_sda_low = 1'b0;
        wr(3'd0, 16'h0000);
        pads_chk("R9 controller mode releases", 1'b0, 1'b0);
        wr(3'd0, 16'h0001);
        pads_chk("R9 latch kept across switch", 1'b1, 1'b0);
    endtask

    task automatic t_level(logic m);
        wr(3'd0, {15'd0, m});
        @(negedge clk);
        scl_pad_in = 1'b0; sda_pad_in = 1'b1;
        rd_chk("R8 before first edge", 3'd2, 16'h3);
        @(negedge clk);
        rd_chk("R8 after one edge old", 3'd2, 16'h3);
        @(negedge clk);
        rd_chk("R8 after two edges new", 3'd2, 16'h2);
        scl_pad_in = 1'b1; sda_pad_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rd_chk("R8 second pattern", 3'd2, 16'h1);
        scl_pad_in = 1'b1; sda_pad_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_controller();
        t_mode();
        t_dir_clr();
        t_set();
        t_zero();
        t_hold();
        t_level(1'b1);
        t_level(1'b0);
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule